// File: doc/BRIEF.md
# Dual-Rate Bus Cycle Stretcher

This block tells a CPU bus how many master-clock ticks each access takes. The master clock runs at 14.31818 MHz. Each access is tagged as slow or fast. A slow access has to line up with a 912-tick video line. That line is made of 14-tick cycles, except that the cycle starting at tick 896 lasts 16 ticks. A fast access lines up with 5-tick slots. A fast access to a writable RAM region also pays a 5-tick refresh penalty in the last slot of a 50-tick refresh window.

The block keeps one phase counter for each rate. Both counters move forward by the full duration of every access, whichever rate the access used. The block also adds up all durations and raises a pulse each time the total passes one second of master ticks.

An access is presented for one clock with `acc_valid`. On the next clock, `done` is high for one cycle. In that cycle `dur_ticks` holds the computed length and both phases have already moved on.

Top module: `bus_cycle_stretcher`

## Requirements
- R1: After reset, both phase counters and the second accumulator are zero and `done` and `sec_pulse` are low. The first slow access therefore takes 14 ticks and the first fast access takes 5 ticks.
- R2: `done` is high for exactly the one cycle after a cycle with `acc_valid` high, and low in every other cycle. `dur_ticks` is meaningful only while `done` is high.
- R3: A slow access at slow phase p (where `acc_slow`=1) works as follows:
  - The current length is L = 16 if p ≥ 896, otherwise 14.
  - The wait is w = (L − p mod 14) mod L.
  - The aligned phase is a = (p + w) mod 912.
  - The duration is w + 16 if a ≥ 896, otherwise w + 14.
- R4: The long final cycle behaves as R3 gives near the end of the line. At p = 896 the duration is 16. At p = 900 it is 26. At p = 910 the wait is zero and the duration is 16. At p = 890 it is 22.
- R5: A fast access (`acc_slow`=0) at fast phase q takes 5 + (5 − q mod 5) mod 5 ticks.
- R6: A fast access with `acc_ramwr`=1 and q ≥ 45 takes 5 extra ticks. `acc_ramwr` has no effect on fast accesses with q < 45 or on any slow access.
- R7: After each access, the slow phase moves forward by the duration modulo 912 and the fast phase moves forward by the duration modulo 50. Idle cycles leave both phases unchanged.
- R8: Durations add up into a tick accumulator. When the sum reaches `TICKS_PER_SEC`, that amount is subtracted and `sec_pulse` is high together with `done` for that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One access is presented this cycle |
| acc_slow | input | 1 | 1 = slow-rate access, 0 = fast-rate access |
| acc_ramwr | input | 1 | Access targets a writable RAM region |
| done | output | 1 | Access complete; result valid this cycle |
| dur_ticks | output | DW (5) | Access length in master ticks |
| sec_pulse | output | 1 | One second of master ticks has elapsed |

## Verification
The bench goes after these cases:
- **Slow accesses that start in the long final cycle.** This covers the phase-910 case, where the alignment wait folds to zero. A design that used a fixed 14-tick length there would report 14 instead of 16, or would report a 12-tick wait where none is due.
- **Fast RAM writes either side of phase 45, and slow RAM writes.** A misplaced refresh compare shows up as an extra or missing 5 ticks.
- **Long mixed random sequences with idle gaps, checked against an arithmetic phase model.** A counter that ignores the other rate's accesses, or that drifts while idle, gives a wrong duration on a later access.
- **The second pulse, checked with a short `TICKS_PER_SEC`.** An off-by-one in the wrap of the accumulator shifts the pulse by one access.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic {
        KIND_FAST = 1'b0,
        KIND_SLOW = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/slow_slot_calc.sv
module slow_slot_calc #(
    parameter int WRAP  = 912,
    parameter int CYC   = 14,
    parameter int EXTRA = 2,
    parameter int PW    = 10,
    parameter int DW    = 5
) (
    input  logic [PW-1:0] phase,
    output logic [DW-1:0] dur
);
    localparam int LONG_AT = WRAP - CYC - EXTRA;
    localparam logic [PW-1:0] SHORT_L = PW'(CYC);
    localparam logic [PW-1:0] LONG_L  = PW'(CYC + EXTRA);
    localparam logic [PW-1:0] AT_P    = PW'(LONG_AT);
    localparam logic [PW:0]   WRAP_P  = (PW+1)'(WRAP);

    logic [PW-1:0] cur_len, rem, wt, aph, nxt_len;
    logic [PW:0]   aph_raw;

    always_comb begin
        cur_len = (phase >= AT_P) ? LONG_L : SHORT_L;
        rem     = phase % SHORT_L;
        wt      = (cur_len - rem) % cur_len;
        aph_raw = {1'b0, phase} + {1'b0, wt};
        aph     = (aph_raw >= WRAP_P) ? PW'(aph_raw - WRAP_P) : aph_raw[PW-1:0];
        nxt_len = (aph >= AT_P) ? LONG_L : SHORT_L;
        dur     = DW'(wt + nxt_len);
    end
endmodule

// File: rtl/fast_slot_calc.sv
module fast_slot_calc #(
    parameter int WRAP = 50,
    parameter int SLOT = 5,
    parameter int PW   = 6,
    parameter int DW   = 5
) (
    input  logic [PW-1:0] phase,
    input  logic          ram_wr,
    output logic [DW-1:0] dur
);
    localparam logic [PW-1:0] SLOT_P = PW'(SLOT);
    localparam logic [PW-1:0] REFR_P = PW'(WRAP - SLOT);

    logic [PW-1:0] rem, wt, penalty;

    always_comb begin
        rem     = phase % SLOT_P;
        wt      = (SLOT_P - rem) % SLOT_P;
        penalty = (ram_wr && phase >= REFR_P) ? SLOT_P : '0;
        dur     = DW'(SLOT_P + wt + penalty);
    end
endmodule

// File: rtl/tick_second.sv
module tick_second #(
    parameter int TPS = 14318180,
    parameter int CW  = 24,
    parameter int DW  = 5
) (
    input  logic [CW-1:0] acc_q,
    input  logic          en,
    input  logic [DW-1:0] add,
    output logic [CW-1:0] acc_d,
    output logic          pulse
);
    localparam logic [CW:0] TPS_P = (CW+1)'(TPS);

    logic [CW:0] sum;

    always_comb begin
        sum   = {1'b0, acc_q} + (CW+1)'(add);
        pulse = 1'b0;
        acc_d = acc_q;
        if (en) begin
            if (sum >= TPS_P) begin
                acc_d = CW'(sum - TPS_P);
                pulse = 1'b1;
            end else begin
                acc_d = sum[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/bus_cycle_stretcher.sv
module bus_cycle_stretcher #(
    parameter int SLOW_WRAP     = 912,
    parameter int SLOW_CYC      = 14,
    parameter int SLOW_EXTRA    = 2,
    parameter int FAST_WRAP     = 50,
    parameter int FAST_SLOT     = 5,
    parameter int TICKS_PER_SEC = 14318180,
    localparam int SLOW_MAX = 2 * (SLOW_CYC + SLOW_EXTRA) - 1,
    localparam int FAST_MAX = 3 * FAST_SLOT - 1,
    localparam int DUR_MAX  = (SLOW_MAX > FAST_MAX) ? SLOW_MAX : FAST_MAX,
    localparam int DW       = $clog2(DUR_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_slow,
    input  logic          acc_ramwr,
    output logic          done,
    output logic [DW-1:0] dur_ticks,
    output logic          sec_pulse
);
    import bcs_pkg::*;

    localparam int SPW = $clog2(SLOW_WRAP);
    localparam int FPW = $clog2(FAST_WRAP);
    localparam int CW  = $clog2(TICKS_PER_SEC);
    localparam logic [SPW:0] SWRAP_P = (SPW+1)'(SLOW_WRAP);
    localparam logic [FPW:0] FWRAP_P = (FPW+1)'(FAST_WRAP);

    typedef struct packed {
        logic [SPW-1:0] sph;
        logic [FPW-1:0] fph;
        logic [CW-1:0]  acc;
        logic [DW-1:0]  dur;
        logic           done;
        logic           sec;
        acc_kind_e      kind;
    } state_t;

    state_t st_q, st_d;

    logic [DW-1:0] slow_dur, fast_dur, sel_dur;
    logic [CW-1:0] acc_nxt;
    logic          sec_nxt;
    logic [SPW:0]  sph_sum;
    logic [FPW:0]  fph_sum;

    slow_slot_calc #(
        .WRAP(SLOW_WRAP), .CYC(SLOW_CYC), .EXTRA(SLOW_EXTRA), .PW(SPW), .DW(DW)
    ) i_slow (
        .phase(st_q.sph),
        .dur  (slow_dur)
    );

    fast_slot_calc #(
        .WRAP(FAST_WRAP), .SLOT(FAST_SLOT), .PW(FPW), .DW(DW)
    ) i_fast (
        .phase (st_q.fph),
        .ram_wr(acc_ramwr),
        .dur   (fast_dur)
    );

    tick_second #(
        .TPS(TICKS_PER_SEC), .CW(CW), .DW(DW)
    ) i_sec (
        .acc_q(st_q.acc),
        .en   (acc_valid),
        .add  (sel_dur),
        .acc_d(acc_nxt),
        .pulse(sec_nxt)
    );

    always_comb begin
        sel_dur = acc_slow ? slow_dur : fast_dur;
        sph_sum = {1'b0, st_q.sph} + (SPW+1)'(sel_dur);
        fph_sum = {1'b0, st_q.fph} + (FPW+1)'(sel_dur);
        st_d      = st_q;
        st_d.done = acc_valid;
        st_d.sec  = sec_nxt;
        st_d.acc  = acc_nxt;
        if (acc_valid) begin
            st_d.dur  = sel_dur;
            st_d.kind = acc_slow ? KIND_SLOW : KIND_FAST;
            st_d.sph  = (sph_sum >= SWRAP_P) ? SPW'(sph_sum - SWRAP_P) : sph_sum[SPW-1:0];
            st_d.fph  = (fph_sum >= FWRAP_P) ? FPW'(fph_sum - FWRAP_P) : fph_sum[FPW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done      = st_q.done;
    assign dur_ticks = st_q.dur;
    assign sec_pulse = st_q.sec;

    a_r2_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> done);
    a_r2_no_done_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !done);
    a_r7_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sph < SPW'(SLOW_WRAP)) && (st_q.fph < FPW'(FAST_WRAP)));
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> ($stable(st_q.sph) && $stable(st_q.fph)));
    a_r3_slow_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.kind == KIND_SLOW) |->
            (dur_ticks >= DW'(SLOW_CYC) && dur_ticks <= DW'(SLOW_MAX)));
    a_r3_slow_ends_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.kind == KIND_SLOW) |-> (st_q.sph % SPW'(SLOW_CYC) == '0));
    a_r5_fast_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.kind == KIND_FAST) |->
            (dur_ticks >= DW'(FAST_SLOT) && dur_ticks <= DW'(FAST_MAX)));
    a_r5_fast_ends_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.kind == KIND_FAST) |-> (st_q.fph % FPW'(FAST_SLOT) == '0));
    a_r8_pulse_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> done);
endmodule

// File: tb/test_bus_cycle_stretcher.sv
module test_bus_cycle_stretcher;
    localparam int TPS = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_slow = 1'b0;
    logic       acc_ramwr = 1'b0;
    logic       done;
    logic [4:0] dur_ticks;
    logic       sec_pulse;

    int checks = 0;
    int errors = 0;
    int sp = 0;
    int fp = 0;
    int macc = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    bus_cycle_stretcher #(.TICKS_PER_SEC(TPS)) i_bus_cycle_stretcher (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_slow(acc_slow),
        .acc_ramwr(acc_ramwr), .done(done), .dur_ticks(dur_ticks), .sec_pulse(sec_pulse)
    );

    always #10 clk = ~clk;

    function automatic int exp_slow(int p);
        int len = (p >= 896) ? 16 : 14;
        int w = (len - (p % 14)) % len;
        int a = (p + w) % 912;
        return w + ((a >= 896) ? 16 : 14);
    endfunction

    function automatic int exp_fast(int q, bit wr);
        int w = (5 - (q % 5)) % 5;
        return 5 + w + ((wr && q >= 45) ? 5 : 0);
    endfunction

    function automatic int unsigned next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", int'(done), 0);
        check(sec_pulse == 1'b0, "R1", int'(sec_pulse), 0);
        sp = 0; fp = 0; macc = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1", int'(done), 0);
    endtask

    task automatic access(bit s, bit wr, bit after_idle);
        int e;
        bit es;
        string tag;
        e = s ? exp_slow(sp) : exp_fast(fp, wr);
        if (after_idle)                tag = "R7";
        else if (s && wr)              tag = "R6";
        else if (s && sp >= 896)       tag = "R4";
        else if (s)                    tag = "R3";
        else if (wr && fp >= 45)       tag = "R6";
        else                           tag = "R5";
        acc_valid = 1'b1;
        acc_slow  = s;
        acc_ramwr = wr;
        @(negedge clk);
        acc_valid = 1'b0;
        macc += e;
        es = 1'b0;
        if (macc >= TPS) begin
            macc -= TPS;
            es = 1'b1;
        end
        sp = (sp + e) % 912;
        fp = (fp + e) % 50;
        check(done == 1'b1, "R2", int'(done), 1);
        check(int'(dur_ticks) == e, tag, int'(dur_ticks), e);
        check(sec_pulse == es, "R8", int'(sec_pulse), int'(es));
    endtask

    task automatic idle(int n);
        acc_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(done == 1'b0, "R2", int'(done), 0);
            check(sec_pulse == 1'b0, "R8", int'(sec_pulse), 0);
        end
    endtask

    initial begin
        do_reset();
        // R1: first slow access from reset takes 14 ticks
        access(1'b1, 1'b0, 1'b0);
        // walk the slow phase to 896, then hit the long cycle (R4)
        for (int i = 0; i < 63; i++) access(1'b1, 1'b0, 1'b0);
        access(1'b1, 1'b0, 1'b0);
        check(sp == 0, "R4", sp, 0);

        do_reset();
        // R1: first fast access from reset takes 5 ticks, RAM write below 45 adds nothing
        access(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) access(1'b0, 1'b0, 1'b0);
        // R6: fast phase is now 45, RAM write pays refresh
        access(1'b0, 1'b1, 1'b0);
        access(1'b0, 1'b0, 1'b0);

        do_reset();
        // mixed sweep with idle gaps (R3..R8)
        for (int k = 0; k < 20000; k++) begin
            int unsigned r = next_rand();
            bit gap = (r[2:0] == 3'd0);
            if (gap) idle(int'(r[4:3]) + 1);
            access(r[6:5] != 2'b00, r[7], gap);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule